// File: doc/BRIEF.md
# I2C Target Stall Watchdog

This block guards an I2C controller while it acts as a bus target. When a peer controller walks away from the bus in the middle of a transfer, the target logic can stay inside that transfer for good. The watchdog measures how long the open target transfer goes without any bus activity. Once a programmed limit passes, it sets a sticky status flag and can raise an interrupt.

The timebase is coarse. A prescaler produces one tick every 2^(BASE_LOG2 + 2*sel) clocks. The default BASE_LOG2 of 14 gives 16384, 65536, 262144 or 1048576 clocks per tick. A tick counter compares against a 5-bit limit. While the controller stays stuck, the flag is raised again after every further full period. Clearing the flag does not end the transfer; only the controller-reset input does that.

The surrounding I2C logic drives four strobes: transfer start, STOP, pin activity (any SCL or SDA edge) and controller reset. A small register port gives access to the timing fields, the interrupt enable and the status bit.

Top module: `i2c_tgt_stall_wdog`

## Requirements
- R1: After rst_ni is deasserted, irq_o and tgt_busy_o are 0 and reads at all four addresses return 0.
- R2: tgt_start_i sets tgt_busy_o on the next cycle. tgt_stop_i clears it. If both arrive in the same cycle, the start wins and tgt_busy_o stays 1.
- R3: The period is measured from the last restart edge. A restart is a start, STOP, bus activity or controller reset, or any cycle in which the block is idle. While busy, the status bit (address 3, bit 15) is set at exactly P*N clock edges after the restart edge. Here P = 2^(BASE_LOG2+2*sel) and N is the tick limit.
- R4: The prescaler select sel is a 2-bit field at address 0, bits 9:8. Each step of sel multiplies the tick period by four.
- R5: The tick limit N is a 5-bit field at address 1, bits 4:0. N = 0 disables the timeout, so the status bit is never set, however long the block stays busy.
- R6: A bus_act_i pulse restarts the period. Activity spaced closer than P*N cycles never sets the status bit.
- R7: While the block stays busy with no activity, the status bit is set again after each further P*N cycles, even after software has cleared it.
- R8: The status bit is sticky. A write to address 3 with bit 15 = 1 clears it, and a write with bit 15 = 0 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the status bit ends up set.
- R9: irq_o is 1 exactly when both the status bit and the enable bit (address 2, bit 15) are 1.
- R10: A ctrl_rst_i pulse clears tgt_busy_o, the counters and the status bit in one cycle, and this wins over a simultaneous expiry. The timing fields and the enable bit are kept.
- R11: A write to sel or N takes effect only at the next restart. A period that is already running completes with the old values.
- R12: While tgt_busy_o is 0, the status bit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_rst_i | input | 1 | Synchronous controller reset strobe |
| tgt_start_i | input | 1 | Target transfer begins (address matched) |
| tgt_stop_i | input | 1 | STOP ends the target transfer |
| bus_act_i | input | 1 | SCL or SDA edge seen on the bus |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 prescale, 1 limit, 2 enable, 3 status |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i |
| tgt_busy_o | output | 1 | Target transfer open |
| irq_o | output | 1 | Stall interrupt |

## Verification
Two pairs of events can meet on one clock edge, and both are provoked on purpose. In the first, a status-clearing write lands on the exact edge where the tick counter expires. In the second, a controller reset lands on that edge. The bench keeps its own count of elapsed cycles since the last restart. It waits until that count is one short of P*N, then issues the write or the reset on the next edge. The expected result is that the status stays set after the write and reads zero after the reset. The same model compares every output on every cycle, so an edge that is off by one cycle is also caught.

// File: rtl/i2c_tgt_stall_wdog_pkg.sv
package i2c_tgt_stall_wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_PRESCALE = 2'd0,
    ADDR_LIMIT    = 2'd1,
    ADDR_IRQ_EN   = 2'd2,
    ADDR_IRQ_STS  = 2'd3
  } wd_addr_e;

  localparam int unsigned SEL_LSB = 8;
  localparam int unsigned LIM_LSB = 0;
  localparam int unsigned IRQ_BIT = 15;
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
  parameter int unsigned BASE_LOG2 = 14,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned PRE_W = BASE_LOG2 + 2 * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  term;

  // counter never passes the terminal value, so all-ones low bits mark it
  for (genvar s = 0; s < NSEL; s++) begin : g_term
    assign term[s] = &pre_q[BASE_LOG2 + 2*s - 1 : 0];
  end

  assign tick_o = run_i & term[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/wd_tick_counter.sv
module wd_tick_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  // widened compare: a zero limit can never match
  assign hit      = ({1'b0, cnt_q} + (CNT_W+1)'(1)) == {1'b0, limit_i};
  assign expire_o = tick_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (expire_o)  cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wd_regs.sv
module wd_regs
  import i2c_tgt_stall_wdog_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ctrl_rst_i,
  input  logic             expire_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             ien_o,
  output logic             sts_o,
  output logic [DW-1:0]    rdata_o
);
  wd_addr_e addr;
  logic     sts_clr;
  logic     unused_wdata;

  assign addr         = wd_addr_e'(addr_i);
  assign sts_clr      = we_i && (addr == ADDR_IRQ_STS) && wdata_i[IRQ_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= '0;
      lim_o <= '0;
      ien_o <= 1'b0;
    end else if (we_i) begin
      unique case (addr)
        ADDR_PRESCALE: sel_o <= wdata_i[SEL_LSB +: SEL_W];
        ADDR_LIMIT:    lim_o <= wdata_i[LIM_LSB +: CNT_W];
        ADDR_IRQ_EN:   ien_o <= wdata_i[IRQ_BIT];
        default: ;
      endcase
    end
  end

  // reset beats expiry, expiry beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sts_o <= 1'b0;
    else if (ctrl_rst_i)  sts_o <= 1'b0;
    else if (expire_i)    sts_o <= 1'b1;
    else if (sts_clr)     sts_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_PRESCALE: rdata_o[SEL_LSB +: SEL_W] = sel_o;
      ADDR_LIMIT:    rdata_o[LIM_LSB +: CNT_W] = lim_o;
      ADDR_IRQ_EN:   rdata_o[IRQ_BIT]          = ien_o;
      ADDR_IRQ_STS:  rdata_o[IRQ_BIT]          = sts_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_tgt_stall_wdog.sv
module i2c_tgt_stall_wdog #(
  parameter int unsigned BASE_LOG2 = 14,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned DW        = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_rst_i,
  input  logic          tgt_start_i,
  input  logic          tgt_stop_i,
  input  logic          bus_act_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          tgt_busy_o,
  output logic          irq_o
);
  logic             busy_q;
  logic             restart;
  logic             run;
  logic             tick;
  logic             expire;
  logic             ien;
  logic             sts;
  logic [SEL_W-1:0] sel_reg, sel_shd;
  logic [CNT_W-1:0] lim_reg, lim_shd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (ctrl_rst_i)  busy_q <= 1'b0;
    else if (tgt_start_i) busy_q <= 1'b1;
    else if (tgt_stop_i)  busy_q <= 1'b0;
  end

  assign restart = ctrl_rst_i | tgt_start_i | tgt_stop_i | bus_act_i | ~busy_q;
  assign run     = busy_q & ~restart & (lim_shd != '0);

  // timing fields are sampled only at a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_shd <= '0;
      lim_shd <= '0;
    end else if (restart) begin
      sel_shd <= sel_reg;
      lim_shd <= lim_reg;
    end
  end

  wd_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .run_i  (run),
    .sel_i  (sel_shd),
    .tick_o (tick)
  );

  wd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart),
    .tick_i   (tick),
    .limit_i  (lim_shd),
    .expire_o (expire)
  );

  wd_regs #(.DW(DW), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ctrl_rst_i (ctrl_rst_i),
    .expire_i   (expire),
    .sel_o      (sel_reg),
    .lim_o      (lim_reg),
    .ien_o      (ien),
    .sts_o      (sts),
    .rdata_o    (reg_rdata_o)
  );

  assign tgt_busy_o = busy_q;
  assign irq_o      = sts & ien;
endmodule

// File: rtl/i2c_tgt_stall_wdog_chk.sv
module i2c_tgt_stall_wdog_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_rst_i,
  input logic          tgt_start_i,
  input logic          tgt_stop_i,
  input logic          bus_act_i,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic          tgt_busy_o,
  input logic          irq_o,
  input logic          expire,
  input logic          sts
);
  logic sw_clr;
  assign sw_clr = reg_we_i && (reg_addr_i == 2'd3) && reg_wdata_i[15];

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_start_i && !ctrl_rst_i) |=> tgt_busy_o);

  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_stop_i && !tgt_start_i && !ctrl_rst_i) |=> !tgt_busy_o);

  p_expire_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl_rst_i) |=> sts);

  p_activity_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |-> !expire);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts && !ctrl_rst_i && !sw_clr) |=> sts);

  p_ctrl_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> (!tgt_busy_o && !sts && !irq_o));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_busy_o |-> !expire);
endmodule

bind i2c_tgt_stall_wdog i2c_tgt_stall_wdog_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_rst_i  (ctrl_rst_i),
  .tgt_start_i (tgt_start_i),
  .tgt_stop_i  (tgt_stop_i),
  .bus_act_i   (bus_act_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tgt_busy_o  (tgt_busy_o),
  .irq_o       (irq_o),
  .expire      (expire),
  .sts         (sts)
);

// File: tb/i2c_tgt_stall_wdog_test.sv
`timescale 1ns/1ps
module i2c_tgt_stall_wdog_test;
  localparam int BL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crst = 1'b0, start = 1'b0, stop = 1'b0, act = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  i2c_tgt_stall_wdog #(.BASE_LOG2(BL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_rst_i(crst), .tgt_start_i(start),
    .tgt_stop_i(stop), .bus_act_i(act), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tgt_busy_o(busy), .irq_o(irq)
  );

  // reference model
  int m_sel, m_cnt, m_ssel, m_scnt, m_el;
  bit m_busy, m_ien, m_sts;

  function automatic int m_tot(int s, int c);
    return (1 << (BL + 2*s)) * c;
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: r[9:8] = 2'(m_sel);
      2'd1: r[4:0] = 5'(m_cnt);
      2'd2: r[15]  = m_ien;
      default: r[15] = m_sts;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_cnt = 0; m_ssel = 0; m_scnt = 0; m_el = 0;
      m_busy = 0; m_ien = 0; m_sts = 0;
    end else begin
      bit fire, rs;
      fire = 0;
      rs = crst | start | stop | act | !m_busy;
      if (rs) begin
        m_el = 0; m_ssel = m_sel; m_scnt = m_cnt;
      end else if (m_scnt != 0) begin
        m_el++;
        if (m_el == m_tot(m_ssel, m_scnt)) begin fire = 1; m_el = 0; end
      end
      if (crst) m_sts = 0;
      else if (fire) m_sts = 1;
      else if (we && addr == 2'd3 && wdata[15]) m_sts = 0;
      if (we) case (addr)
        2'd0: m_sel = int'(wdata[9:8]);
        2'd1: m_cnt = int'(wdata[4:0]);
        2'd2: m_ien = wdata[15];
        default: ;
      endcase
      if (crst) m_busy = 0;
      else if (start) m_busy = 1;
      else if (stop) m_busy = 0;
    end
  end

  task automatic chk(string t, string what, logic [31:0] act_v, logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", t, what, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(tag, "cyc_busy", 32'(busy), 32'(m_busy));
      chk(tag, "cyc_irq", 32'(irq), 32'(m_ien & m_sts));
      chk(tag, "cyc_rdata", rdata, m_read(addr));
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 2'd3; wdata = '0;
  endtask
  task automatic p_start(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic p_stop();  @(negedge clk); stop = 1;  @(negedge clk); stop = 0;  endtask
  task automatic p_act();   @(negedge clk); act = 1;   @(negedge clk); act = 0;   endtask
  task automatic p_crst();  @(negedge clk); crst = 1;  @(negedge clk); crst = 0;  endtask
  // returns at the negedge before the edge on which the model expires
  task automatic to_fire_edge();
    @(negedge clk);
    while (!(m_busy && m_scnt != 0 && m_el == m_tot(m_ssel, m_scnt) - 1)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "busy", 32'(busy), 0);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); @(negedge clk);
      chk("R1", "rdata", rdata, 0);
    end
    addr = 2'd3;

    tag = "R5";
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_8000);
    addr = 2'd1; @(negedge clk); chk("R5", "limit_rd", rdata, 32'h3); addr = 2'd3;

    tag = "R3";
    p_start();
    chk("R2", "busy_after_start", 32'(busy), 1);
    idle(23); chk("R3", "sts_early", rdata, 0);
    idle(1);  chk("R3", "sts_on_time", rdata, 32'h8000);

    tag = "R9";
    chk("R9", "irq_on", 32'(irq), 1);
    wr(2'd2, 32'h0); chk("R9", "irq_masked", 32'(irq), 0);
    wr(2'd2, 32'h8000); chk("R9", "irq_unmasked", 32'(irq), 1);

    tag = "R8";
    wr(2'd3, 32'h0000_7fff); chk("R8", "sts_kept", rdata, 32'h8000);
    wr(2'd3, 32'h0000_8000); chk("R8", "sts_cleared", rdata, 0);

    tag = "R7";
    to_fire_edge(); idle(1); chk("R7", "refire", rdata, 32'h8000);
    wr(2'd3, 32'h8000);
    to_fire_edge(); idle(1); chk("R7", "refire2", rdata, 32'h8000);

    tag = "R8";
    to_fire_edge();
    we = 1; addr = 2'd3; wdata = 32'h8000;
    @(negedge clk); we = 0; wdata = '0;
    chk("R8", "expire_beats_clear", rdata, 32'h8000);

    tag = "R10";
    p_crst();
    chk("R10", "busy_cleared", 32'(busy), 0);
    chk("R10", "sts_cleared", rdata, 0);
    addr = 2'd1; @(negedge clk); chk("R10", "limit_kept", rdata, 32'h3);
    addr = 2'd2; @(negedge clk); chk("R10", "ien_kept", rdata, 32'h8000);
    addr = 2'd3;
    p_start();
    to_fire_edge();
    crst = 1; @(negedge clk); crst = 0;
    chk("R10", "rst_beats_expire", rdata, 0);

    tag = "R6";
    p_start();
    for (int i = 0; i < 10; i++) begin idle(9); p_act(); end
    chk("R6", "no_fire_with_activity", rdata, 0);
    p_stop();
    chk("R2", "busy_after_stop", 32'(busy), 0);

    tag = "R11";
    p_start();
    idle(4);
    wr(2'd1, 32'h1);
    idle(17); chk("R11", "old_period_early", rdata, 0);
    idle(1);  chk("R11", "old_period_fires", rdata, 32'h8000);
    wr(2'd3, 32'h8000);
    p_act();
    idle(7); chk("R11", "new_period_early", rdata, 0);
    idle(1); chk("R11", "new_period_fires", rdata, 32'h8000);

    tag = "R4";
    p_crst();
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h2);
    p_start();
    idle(63); chk("R4", "sel1_early", rdata, 0);
    idle(1);  chk("R4", "sel1_fires", rdata, 32'h8000);

    tag = "R5";
    p_crst();
    wr(2'd1, 32'h0);
    p_start();
    idle(600);
    chk("R5", "zero_limit_no_fire", rdata, 0);
    chk("R5", "still_busy", 32'(busy), 1);

    tag = "R12";
    p_crst();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1);
    idle(100);
    chk("R12", "idle_no_fire", rdata, 0);

    tag = "R2";
    @(negedge clk); start = 1; stop = 1;
    @(negedge clk); start = 0; stop = 0;
    chk("R2", "start_wins", 32'(busy), 1);
    p_stop();
    chk("R2", "stop_clears", 32'(busy), 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule